// File: doc/BRIEF.md
# Stereo Transmit Sample Buffer

This block is the transmit-side sample store of a serial audio port. A producer (software or a DMA engine) writes the left and the right half of each stereo sample through two separate write ports. A pair enters the buffer only once both of its halves have arrived. The serializer asks for one pair per audio frame with a pop strobe. The block answers on a registered left/right output pair.

The block reports its fill level, a full flag, and two sticky error flags. One flag records writes that arrived while the buffer was full. The other records pops that found the buffer empty; such a pop sends out a silent (zero) pair. One interrupt line carries two sources:

- a low-water request, whose threshold is either half empty or fully empty, selected by a control bit;
- an optional underflow request.

A port-wide enable and a channel enable gate the whole path. Dropping either one empties the buffer, discards any half-written pair and silences the outputs. Toggling the channel enable off and on therefore returns the channel to a clean, aligned state after an underflow has left it confused.

Top module: `stereo_tx_buffer`

## Requirements
- R1: During and right after reset, the fill level is 0, the full flag is 0, both sticky flags are 0, both sample outputs are zero and the interrupt is low while the enables are low.
- R2: A pair is committed only when both a left and a right write have been seen, in either order or in the same cycle. A second write to the same half before its partner arrives replaces the held value.
- R3: The buffer holds DEPTH pairs (8 by default). The full flag is 1 exactly when the level equals DEPTH. A pair completed while full is dropped and sets the sticky overflow flag in the next cycle.
- R4: A pop with a non-empty buffer presents the oldest stored pair on the outputs in the cycle after the pop. Pairs leave in the order they were committed, and the outputs hold their value between pops.
- R5: A pop with an empty buffer presents zero on both outputs in the next cycle and sets the sticky underflow flag.
- R6: Each sticky flag stays set until its clear input is pulsed. If a new event arrives in the same cycle as the clear, the event wins and the flag stays set.
- R7: With the watermark select at 0, the interrupt is high while the level is at most DEPTH/2. With the select at 1, the interrupt is high only while the level is 0.
- R8: With the underflow-interrupt enable at 1, a set underflow flag drives the interrupt high regardless of the level.
- R9: While the port enable or the channel enable is low, the buffer is emptied, any held half pair is discarded, the outputs read zero from the next cycle, writes and pops have no effect, and the interrupt is low.
- R10: Fullness is judged on the level before the cycle's pop. A pair completed in the same cycle as a pop from a full buffer is still dropped and flagged as overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Port-wide enable |
| chan_en | input | 1 | Transmit channel enable |
| wm_sel | input | 1 | Low-water threshold: 0 = half empty, 1 = empty |
| unf_ie | input | 1 | Underflow interrupt enable |
| left_wr | input | 1 | Left half write strobe |
| left_data | input | SAMPLE_W | Left half sample |
| right_wr | input | 1 | Right half write strobe |
| right_data | input | SAMPLE_W | Right half sample |
| pop_req | input | 1 | Serializer request for the next pair |
| ovf_clr | input | 1 | Clear pulse for the overflow flag |
| unf_clr | input | 1 | Clear pulse for the underflow flag |
| out_left | output | SAMPLE_W | Left sample presented to the serializer |
| out_right | output | SAMPLE_W | Right sample presented to the serializer |
| fill_level | output | $clog2(DEPTH+1) | Number of stored pairs |
| full | output | 1 | Buffer full |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Most internal faults surface at the ports within one cycle.

- A broken read or write pointer shows up at the next pop as a pair out of order or a repeated pair, and on the fill level as soon as the count drifts.
- A half-pair tracker that commits too early raises the level after a single-sided write.
- A missing flush leaves a nonzero level, or stale samples, one cycle after an enable drops.

The error flags and the interrupt are compared on every cycle, against a model of the committed pairs, so a wrong threshold or a lost sticky bit is reported on the cycle it diverges.

// File: rtl/txbuf_pkg.sv
// Shared defaults and the watermark encoding for the stereo transmit buffer.
package txbuf_pkg;
    localparam int unsigned SAMPLE_W_DEF = 24;
    localparam int unsigned DEPTH_DEF    = 8;

    // Low-water threshold selection.
    typedef enum logic {
        WM_HALF  = 1'b0,
        WM_EMPTY = 1'b1
    } watermark_e;
endpackage

// File: rtl/txbuf_pair_join.sv
// Collects a left and a right half and reports a committed pair.
// Assumes: the halves may arrive in any order; a repeated half overwrites
// the held one; everything held is discarded while 'active' is low.
module txbuf_pair_join #(
    parameter int unsigned SAMPLE_W = 24,
    localparam int unsigned PAIR_W  = 2 * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                left_wr,
    input  logic [SAMPLE_W-1:0] left_data,
    input  logic                right_wr,
    input  logic [SAMPLE_W-1:0] right_data,
    output logic                commit,
    output logic [PAIR_W-1:0]   pair_data
);
    logic                have_l, have_r;
    logic [SAMPLE_W-1:0] hold_l, hold_r;
    logic                take_l, take_r;

    // Pair is complete when each half is either held or arriving now.
    always_comb begin
        take_l    = have_l | left_wr;
        take_r    = have_r | right_wr;
        commit    = active & take_l & take_r;
        pair_data = {(left_wr ? left_data : hold_l), (right_wr ? right_data : hold_r)};
    end

    // Track which halves are waiting for their partner.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            have_l <= 1'b0;
            have_r <= 1'b0;
        end else if (commit) begin
            have_l <= 1'b0;
            have_r <= 1'b0;
        end else begin
            if (left_wr)  have_l <= 1'b1;
            if (right_wr) have_r <= 1'b1;
        end
    end

    // Keep the most recent value written to each half.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            hold_l <= '0;
            hold_r <= '0;
        end else begin
            if (left_wr)  hold_l <= left_data;
            if (right_wr) hold_r <= right_data;
        end
    end
endmodule

// File: rtl/txbuf_store.sv
// Circular store of DEPTH pairs with a level counter.
// Assumes: push and pop are judged on the level at the start of the cycle;
// a flush empties the store synchronously and takes priority.
module txbuf_store #(
    parameter int unsigned PAIR_W = 48,
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [PAIR_W-1:0] wdata,
    input  logic              pop,
    output logic [PAIR_W-1:0] head,
    output logic [CW-1:0]     level,
    output logic              is_full,
    output logic              is_empty,
    output logic              pop_ok
);
    logic [PAIR_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              push_ok;

    // Accept operations only against the current level.
    always_comb begin
        is_full  = (level == CW'(DEPTH));
        is_empty = (level == '0);
        push_ok  = push & ~is_full;
        pop_ok   = pop & ~is_empty;
        head     = mem[rd_ptr];
    end

    // One write-enabled register per entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (push_ok && !flush && wr_ptr == AW'(i))
                mem[i] <= wdata;
        end
    end

    // Advance the pointers with wrap and keep the level in step.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/txbuf_events.sv
// Sticky error flags and the interrupt combiner.
// Assumes: event inputs are already qualified by the channel being active;
// a set event outranks a clear in the same cycle.
module txbuf_events #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   active,
    input  txbuf_pkg::watermark_e  wm,
    input  logic                   unf_ie,
    input  logic [CW-1:0]          level,
    input  logic                   ovf_evt,
    input  logic                   unf_evt,
    input  logic                   ovf_clr,
    input  logic                   unf_clr,
    output logic                   ovf_flag,
    output logic                   unf_flag,
    output logic                   irq
);
    logic low_water;

    // Hold each flag until cleared; a new event keeps it set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            ovf_flag <= ovf_evt | (ovf_flag & ~ovf_clr);
            unf_flag <= unf_evt | (unf_flag & ~unf_clr);
        end
    end

    // Pick the low-water threshold and merge the interrupt sources.
    always_comb begin
        if (wm == txbuf_pkg::WM_EMPTY)
            low_water = (level == '0);
        else
            low_water = (level <= CW'(DEPTH / 2));
        irq = active & (low_water | (unf_ie & unf_flag));
    end
endmodule

// File: rtl/stereo_tx_buffer.sv
// Transmit sample buffer for a stereo serial audio port.
// Assumes: the serializer pops at most one pair per cycle and uses the
// outputs from the cycle after its pop; both enables are level signals.
module stereo_tx_buffer #(
    parameter int unsigned SAMPLE_W = txbuf_pkg::SAMPLE_W_DEF,
    parameter int unsigned DEPTH    = txbuf_pkg::DEPTH_DEF,
    localparam int unsigned PAIR_W  = 2 * SAMPLE_W,
    localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                port_en,
    input  logic                chan_en,
    input  logic                wm_sel,
    input  logic                unf_ie,
    input  logic                left_wr,
    input  logic [SAMPLE_W-1:0] left_data,
    input  logic                right_wr,
    input  logic [SAMPLE_W-1:0] right_data,
    input  logic                pop_req,
    input  logic                ovf_clr,
    input  logic                unf_clr,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right,
    output logic [CW-1:0]       fill_level,
    output logic                full,
    output logic                ovf_flag,
    output logic                unf_flag,
    output logic                irq
);
    logic              active;
    logic              commit;
    logic [PAIR_W-1:0] pair_data;
    logic [PAIR_W-1:0] head;
    logic              is_empty;
    logic              pop_ok;
    logic              ovf_evt, unf_evt;

    // Channel runs only when both enables are set.
    always_comb begin
        active  = port_en & chan_en;
        ovf_evt = commit & full;
        unf_evt = active & pop_req & is_empty;
    end

    txbuf_pair_join #(.SAMPLE_W(SAMPLE_W)) u_join (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .left_wr    (left_wr),
        .left_data  (left_data),
        .right_wr   (right_wr),
        .right_data (right_data),
        .commit     (commit),
        .pair_data  (pair_data)
    );

    txbuf_store #(.PAIR_W(PAIR_W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (~active),
        .push     (commit),
        .wdata    (pair_data),
        .pop      (active & pop_req),
        .head     (head),
        .level    (fill_level),
        .is_full  (full),
        .is_empty (is_empty),
        .pop_ok   (pop_ok)
    );

    txbuf_events #(.DEPTH(DEPTH)) u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .wm       (txbuf_pkg::watermark_e'(wm_sel)),
        .unf_ie   (unf_ie),
        .level    (fill_level),
        .ovf_evt  (ovf_evt),
        .unf_evt  (unf_evt),
        .ovf_clr  (ovf_clr),
        .unf_clr  (unf_clr),
        .ovf_flag (ovf_flag),
        .unf_flag (unf_flag),
        .irq      (irq)
    );

    // Present the head pair on a pop, silence on an empty pop or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            out_left  <= '0;
            out_right <= '0;
        end else if (pop_req) begin
            if (pop_ok) begin
                out_left  <= head[PAIR_W-1:SAMPLE_W];
                out_right <= head[SAMPLE_W-1:0];
            end else begin
                out_left  <= '0;
                out_right <= '0;
            end
        end
    end
endmodule

// File: rtl/txbuf_checks.sv
// Port-level properties of the stereo transmit buffer, bound to the top.
module txbuf_checks #(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned DEPTH    = 8,
    localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                port_en,
    input logic                chan_en,
    input logic                pop_req,
    input logic                ovf_clr,
    input logic [SAMPLE_W-1:0] out_left,
    input logic [SAMPLE_W-1:0] out_right,
    input logic [CW-1:0]       fill_level,
    input logic                full,
    input logic                ovf_flag,
    input logic                unf_flag,
    input logic                irq
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CW'(DEPTH)); // R3

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && chan_en && full && !pop_req) |=> full); // R3

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && chan_en) |=> (int'(fill_level) <= int'($past(fill_level)) + 1)); // R2

    AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && chan_en && pop_req && fill_level == '0)
        |=> (out_left == '0 && out_right == '0 && unf_flag)); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag); // R6

    AST_EMPTY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && chan_en && fill_level == '0) |-> irq); // R7

    AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_en && chan_en) |=> (fill_level == '0 && out_left == '0 && out_right == '0)); // R9

    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_en && chan_en) |-> !irq); // R9
endmodule

bind stereo_tx_buffer txbuf_checks #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_checks (.*);

// File: tb/stereo_tx_buffer_bench.sv
`timescale 1ns/1ps
module stereo_tx_buffer_bench;
    localparam int W = 24;
    localparam int D = 8;
    localparam int CW = $clog2(D + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pe = 0, ce = 0, wm = 0, ue = 0, lw = 0, rw = 0, pp = 0, co = 0, cu = 0;
    logic [W-1:0] ld = '0, rd = '0;
    logic [W-1:0] o_l, o_r;
    logic [CW-1:0] lvl;
    logic o_full, o_ovf, o_unf, o_irq;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [W-1:0] q_l[$];
    logic [W-1:0] q_r[$];
    logic m_hl = 0, m_hr = 0;
    logic [W-1:0] m_hld = '0, m_hrd = '0, m_ol = '0, m_or = '0;
    logic m_ovf = 0, m_unf = 0;

    always #2.5 clk = ~clk;

    stereo_tx_buffer u_stereo_tx_buffer (
        .clk(clk), .rst_n(rst_n), .port_en(pe), .chan_en(ce), .wm_sel(wm), .unf_ie(ue),
        .left_wr(lw), .left_data(ld), .right_wr(rw), .right_data(rd), .pop_req(pp),
        .ovf_clr(co), .unf_clr(cu), .out_left(o_l), .out_right(o_r), .fill_level(lvl),
        .full(o_full), .ovf_flag(o_ovf), .unf_flag(o_unf), .irq(o_irq)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_irq();
        logic low;
        low = wm ? (q_l.size() == 0) : (q_l.size() <= D / 2);
        return pe & ce & (low | (ue & m_unf));
    endfunction

    // Advance the model by one clock using the inputs applied this cycle.
    task automatic model_step();
        int sz;
        logic ovf_set, unf_set;
        ovf_set = 0; unf_set = 0;
        if (!(pe && ce)) begin
            q_l.delete(); q_r.delete();
            m_hl = 0; m_hr = 0; m_ol = '0; m_or = '0;
        end else begin
            sz = q_l.size();
            if ((m_hl | lw) && (m_hr | rw)) begin
                if (sz < D) begin
                    q_l.push_back(lw ? ld : m_hld);
                    q_r.push_back(rw ? rd : m_hrd);
                end else ovf_set = 1;
                m_hl = 0; m_hr = 0;
            end else begin
                if (lw) begin m_hl = 1; m_hld = ld; end
                if (rw) begin m_hr = 1; m_hrd = rd; end
            end
            if (pp) begin
                if (sz > 0) begin
                    m_ol = q_l.pop_front(); m_or = q_r.pop_front();
                end else begin
                    m_ol = '0; m_or = '0; unf_set = 1;
                end
            end
        end
        m_ovf = ovf_set | (m_ovf & ~co);
        m_unf = unf_set | (m_unf & ~cu);
    endtask

    task automatic compare_all();
        chk("R3 level", lvl, q_l.size());
        chk("R3 full", o_full, q_l.size() == D);
        chk("R4 left out", o_l, m_ol);
        chk("R4 right out", o_r, m_or);
        chk("R6 ovf flag", o_ovf, m_ovf);
        chk("R6 unf flag", o_unf, m_unf);
        chk("R7 irq", o_irq, exp_irq());
    endtask

    // One clock: inputs already driven at a falling edge.
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        lw = 0; rw = 0; pp = 0; co = 0; cu = 0;
    endtask

    task automatic put(input logic [W-1:0] l, input logic [W-1:0] r);
        lw = 1; ld = l; rw = 1; rd = r; tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 level", lvl, 0); chk("R1 full", o_full, 0);
        chk("R1 ovf", o_ovf, 0); chk("R1 unf", o_unf, 0);
        chk("R1 outs", {o_l, o_r}, 0); chk("R1 irq", o_irq, 0);
        rst_n = 1; tick();

        pe = 1; ce = 1; wm = 0; tick();
        // R2: half pairs
        lw = 1; ld = 24'h111111; tick();
        chk("R2 left alone no commit", lvl, 0);
        lw = 1; ld = 24'h222222; tick();
        rw = 1; rd = 24'h333333; tick();
        chk("R2 pair after right", lvl, 1);
        rw = 1; rd = 24'h444444; tick();
        lw = 1; ld = 24'h555555; tick();
        chk("R2 reverse order", lvl, 2);
        put(24'h666666, 24'h777777);
        chk("R2 same cycle", lvl, 3);
        // R3: fill and overflow
        for (int i = 0; i < 5; i++) put(24'h100 + W'(i), 24'h200 + W'(i));
        chk("R3 full at depth", o_full, 1);
        chk("R7 half watermark off when full", o_irq, 0);
        co = 1; put(24'hDEAD, 24'hBEEF);
        chk("R3 dropped", lvl, D);
        chk("R6 set beats clear", o_ovf, 1);
        co = 1; tick();
        chk("R6 cleared", o_ovf, 0);
        // R10: pop from full with a completing pair
        pp = 1; lw = 1; ld = 24'hABC; rw = 1; rd = 24'hDEF; tick();
        chk("R10 drop with pop", o_ovf, 1);
        chk("R4 oldest first", o_l, 24'h222222);
        chk("R10 level", lvl, D - 1);
        co = 1; tick();
        // R4 / R5: drain and underflow
        for (int i = 0; i < D - 1; i++) begin pp = 1; tick(); end
        chk("R4 last pair", o_l, 24'h104);
        wm = 1; tick();
        chk("R7 empty watermark", o_irq, 1);
        put(24'h9, 24'h9);
        chk("R7 empty watermark off", o_irq, 0);
        pp = 1; tick();
        pp = 1; tick();
        chk("R5 zero left", o_l, 0); chk("R5 zero right", o_r, 0);
        chk("R5 unf flag", o_unf, 1);
        put(24'h1, 24'h1);
        chk("R8 masked", o_irq, 0);
        ue = 1; tick();
        chk("R8 unf irq", o_irq, 1);
        cu = 1; tick(); ue = 0;
        // R9: disable flushes and ignores
        put(24'h5, 24'h6); lw = 1; ld = 24'h7; tick();
        ce = 0; tick();
        chk("R9 flushed", lvl, 0);
        rw = 1; rd = 24'h8; pp = 1; tick();
        chk("R9 ignored", lvl, 0); chk("R9 irq off", o_irq, 0);
        ce = 1; tick();
        rw = 1; rd = 24'h8; tick();
        chk("R9 half pair discarded", lvl, 0);
        // random mix
        for (int n = 0; n < 4000; n++) begin
            lw = ($urandom % 3) == 0; ld = W'($urandom);
            rw = ($urandom % 3) == 0; rd = W'($urandom);
            pp = ($urandom % 4) == 0;
            co = ($urandom % 16) == 0; cu = ($urandom % 16) == 0;
            if (($urandom % 64) == 0) wm = ~wm;
            if (($urandom % 64) == 0) ue = ~ue;
            ce = ($urandom % 200) != 0;
            pe = ($urandom % 300) != 0;
            tick();
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule